// File: doc/BRIEF.md
# LPC I/O Mailbox Target

This block is a Low Pin Count bus target that runs on the LPC clock. It watches the frame strobe and the 4-bit address/data bus, decodes host I/O read and I/O write cycles, and claims those whose 16-bit address falls inside one of three mailbox channels. A claimed cycle is answered with a ready sync nibble, and for reads the returned byte follows. All other cycles pass by with the bus left undriven.

Each channel has an input byte that the host writes, an output byte that the host reads, and a status byte. The host reaches a channel through an address pair: the base address carries data and base+1 carries commands (for writes) or status (for reads). Channel 3 also has a sixteen-byte shared window that both sides can read and write. An embedded CPU reaches everything through a simple local register port: channel bytes, base addresses and per-channel enables. A single host interrupt line reports waiting output data.

Top module: `lpc_mailbox`

## Requirements
- R1: A cycle starts on a clock where `lframe_n` is low and `lad_in` is 0000. The next nibble is the cycle type: 0000 is an I/O read and 0010 an I/O write. Any other type is ignored, with no bus drive and no change to any channel.
- R2: The address follows as four nibbles, most significant first. A cycle is claimed only when the address hits an enabled channel, that is its base (data) or base+1 (command/status), or for channel 3 the window base+0x10 to base+0x1F (modulo 2^16). A cycle that misses is never driven.
- R3: `lframe_n` low at any point abandons the cycle in progress. The bus is released on the next clock and the abandoned cycle has no effect.
- R4: Write timing: two data nibbles follow the address, low nibble first, then two host turnaround clocks. The target then drives 0000 (ready) for one clock, drives 1111 for one clock, and releases the bus.
- R5: Read timing: two host turnaround clocks follow the address. The target then drives 0000, the data low nibble, the data high nibble and 1111, one clock each, and releases the bus. It never drives longer than four clocks in a row.
- R6: A host write to base or base+1 loads the channel input byte and sets input-full (status bit 1). Status bit 3 records 0 for base and 1 for base+1. A local read of the input byte clears input-full.
- R7: A local write to the output byte sets output-full (status bit 0). A host read at base returns the output byte and clears output-full. A host read at base+1 returns the status byte (other status bits read 0) and changes nothing.
- R8: The channel 3 window bytes at host offsets 0x10 to 0x1F equal local addresses 0x20 to 0x2F. Each side reads what either side last wrote.
- R9: `host_irq` is high exactly while some channel with its interrupt enable set holds output-full.
- R10: When channel address ranges overlap, channel 1's pair wins over channel 2's, channel 2's wins over channel 3's, and the pairs win over the window.
- R11: `lreset_n` low returns the cycle decoder to idle, releases the bus and clears all flags, bytes, bases and enables.
- R12: Local map, channel c = 0,1,2 at 8*c: +0 input byte (read), +1 output byte (write/read), +2 status, +3 base low byte, +4 base high byte, +5 control (bit 0 channel enable, bit 1 interrupt enable). Unmapped local addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | LPC clock |
| lreset_n | input | 1 | Active-low asynchronous reset |
| lframe_n | input | 1 | Active-low frame strobe |
| lad_in | input | 4 | Address/data nibble from the bus |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Bus drive enable |
| host_irq | output | 1 | Host interrupt request |
| loc_we | input | 1 | Local write strobe |
| loc_re | input | 1 | Local read strobe (read side effects) |
| loc_addr | input | 6 | Local register address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data |

## Verification
The bench builds the block with the default window offset of 0x10. Channel 3's base is placed at 0xFFF0, so the window wraps to host addresses 0x0000 to 0x000F, which exercises the modulo-2^16 decode. Bases are reprogrammed during the run to force overlaps for the priority rule and to disable a channel. The random phase mixes host cycles at pair, window and unmapped addresses with local traffic, so flag set and clear orderings and interrupt changes occur in many sequences.

// File: rtl/lpc_mailbox.sv
module lpc_mailbox #(
  parameter logic [15:0] EXT_OFFSET = 16'h0010
) (
  input  logic       lclk,
  input  logic       lreset_n,
  input  logic       lframe_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  output logic       host_irq,
  input  logic       loc_we,
  input  logic       loc_re,
  input  logic [5:0] loc_addr,
  input  logic [7:0] loc_wdata,
  output logic [7:0] loc_rdata
);
  localparam int NCH = 3;
  localparam int EXT_BYTES = 16;

  typedef enum logic [2:0] {S_IDLE, S_CYC, S_ADDR, S_WDAT, S_TAR, S_SYNC, S_RDAT, S_TARX} st_t;

  st_t         st;
  logic [1:0]  cnt;
  logic        is_wr;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata;
  logic [15:0] base [NCH];
  logic [7:0]  ind [NCH];
  logic [7:0]  outd [NCH];
  logic [7:0]  ext [EXT_BYTES];
  logic [NCH-1:0] en, ien, ibf, obf, cd;

  logic        hit, hcd, hext;
  logic [1:0]  hch;
  logic [3:0]  eidx;
  logic [15:0] off3;
  logic [7:0]  hrd;
  logic        host_wr, host_rd;

  function automatic logic [7:0] status(input int c);
    return {4'b0, cd[c], 1'b0, ibf[c], obf[c]};
  endfunction

  always_comb begin
    hit = 1'b0; hcd = 1'b0; hext = 1'b0; hch = 2'd0; eidx = 4'd0;
    off3 = addr - base[2];
    if (en[2] && off3[15:4] == EXT_OFFSET[15:4]) begin
      hit = 1'b1; hext = 1'b1; eidx = off3[3:0];
    end
    for (int i = NCH - 1; i >= 0; i--)
      if (en[i] && (addr == base[i] || addr == base[i] + 16'd1)) begin
        hit = 1'b1; hext = 1'b0; hch = 2'(i); hcd = (addr != base[i]);
      end
  end

  assign hrd     = hext ? ext[eidx] : hcd ? status(int'(hch)) : outd[hch];
  assign host_wr = lframe_n && st == S_SYNC && is_wr && hit;
  assign host_rd = lframe_n && st == S_SYNC && !is_wr && hit;

  assign lad_oe   = st == S_SYNC || st == S_RDAT || st == S_TARX;
  assign lad_out  = st == S_SYNC ? 4'h0 :
                    st == S_RDAT ? (cnt == 2'd0 ? rdata[3:0] : rdata[7:4]) : 4'hF;
  assign host_irq = |(obf & ien);

  logic [1:0] lch;
  logic [2:0] loff;
  logic       lchv;
  assign lch  = loc_addr[4:3];
  assign loff = loc_addr[2:0];
  assign lchv = !loc_addr[5] && lch != 2'd3;

  always_comb begin
    loc_rdata = 8'h00;
    if (loc_addr[5]) begin
      if (!loc_addr[4]) loc_rdata = ext[loc_addr[3:0]];
    end else if (lchv) begin
      case (loff)
        3'd0: loc_rdata = ind[lch];
        3'd1: loc_rdata = outd[lch];
        3'd2: loc_rdata = status(int'(lch));
        3'd3: loc_rdata = base[lch][7:0];
        3'd4: loc_rdata = base[lch][15:8];
        3'd5: loc_rdata = {6'b0, ien[lch], en[lch]};
        default: loc_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge lclk or negedge lreset_n) begin
    if (!lreset_n) begin
      st <= S_IDLE; cnt <= '0; is_wr <= 1'b0; addr <= '0; wdata <= '0; rdata <= '0;
      en <= '0; ien <= '0; ibf <= '0; obf <= '0; cd <= '0;
      for (int i = 0; i < NCH; i++) begin base[i] <= '0; ind[i] <= '0; outd[i] <= '0; end
      for (int i = 0; i < EXT_BYTES; i++) ext[i] <= '0;
    end else begin
      if (!lframe_n) st <= (lad_in == 4'h0) ? S_CYC : S_IDLE;
      else case (st)
        S_CYC: begin
          cnt <= '0;
          if (lad_in == 4'h0)      begin is_wr <= 1'b0; st <= S_ADDR; end
          else if (lad_in == 4'h2) begin is_wr <= 1'b1; st <= S_ADDR; end
          else st <= S_IDLE;
        end
        S_ADDR: begin
          addr <= {addr[11:0], lad_in};
          cnt  <= cnt + 2'd1;
          if (cnt == 2'd3) begin cnt <= '0; st <= is_wr ? S_WDAT : S_TAR; end
        end
        S_WDAT: begin
          if (cnt == 2'd0) wdata[3:0] <= lad_in; else wdata[7:4] <= lad_in;
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) begin cnt <= '0; st <= S_TAR; end
        end
        S_TAR: begin
          if (!hit) st <= S_IDLE;
          else begin
            cnt <= cnt + 2'd1;
            if (cnt == 2'd1) begin cnt <= '0; st <= S_SYNC; end
          end
        end
        S_SYNC: begin rdata <= hrd; cnt <= '0; st <= is_wr ? S_TARX : S_RDAT; end
        S_RDAT: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd1) begin cnt <= '0; st <= S_TARX; end
        end
        default: st <= S_IDLE;
      endcase

      if (loc_we && lchv)
        case (loff)
          3'd1: begin outd[lch] <= loc_wdata; obf[lch] <= 1'b1; end
          3'd3: base[lch][7:0]  <= loc_wdata;
          3'd4: base[lch][15:8] <= loc_wdata;
          3'd5: begin en[lch] <= loc_wdata[0]; ien[lch] <= loc_wdata[1]; end
          default: ;
        endcase
      if (loc_we && loc_addr[5] && !loc_addr[4]) ext[loc_addr[3:0]] <= loc_wdata;
      if (loc_re && lchv && loff == 3'd0) ibf[lch] <= 1'b0;

      if (host_wr) begin
        if (hext) ext[eidx] <= wdata;
        else begin ind[hch] <= wdata; ibf[hch] <= 1'b1; cd[hch] <= hcd; end
      end
      if (host_rd && !hext && !hcd) obf[hch] <= 1'b0;
    end
  end
endmodule

// File: rtl/lpc_mailbox_chk.sv
module lpc_mailbox_chk (
  input logic       lclk,
  input logic       lreset_n,
  input logic       lframe_n,
  input logic       lad_oe,
  input logic [3:0] lad_out,
  input logic       host_irq,
  input logic       loc_we,
  input logic [5:0] loc_addr,
  input logic [2:0] ien,
  input logic [2:0] ibf,
  input logic       host_wr
);
  logic [2:0] run;
  always_ff @(posedge lclk or negedge lreset_n)
    if (!lreset_n) run <= '0;
    else run <= lad_oe ? ((run == 3'd7) ? run : run + 3'd1) : 3'd0;

  assert_abort_release_R3: assert property (@(posedge lclk) disable iff (!lreset_n)
    !lframe_n |=> !lad_oe);

  assert_sync_first_R4: assert property (@(posedge lclk) disable iff (!lreset_n)
    $rose(lad_oe) |-> lad_out == 4'h0);

  assert_drive_len_R5: assert property (@(posedge lclk) disable iff (!lreset_n)
    lad_oe |-> run < 3'd4);

  assert_ibf_source_R6: assert property (@(posedge lclk) disable iff (!lreset_n)
    (ibf & ~$past(ibf)) != 3'b000 |-> $past(host_wr));

  assert_irq_rise_R9: assert property (@(posedge lclk) disable iff (!lreset_n)
    (loc_we && loc_addr == 6'h01 && ien[0]) |=> host_irq);
endmodule

bind lpc_mailbox lpc_mailbox_chk u_chk (
  .lclk(lclk), .lreset_n(lreset_n), .lframe_n(lframe_n), .lad_oe(lad_oe),
  .lad_out(lad_out), .host_irq(host_irq), .loc_we(loc_we), .loc_addr(loc_addr),
  .ien(ien), .ibf(ibf), .host_wr(host_wr)
);

// File: tb/sim_lpc_mailbox.sv
`timescale 1ns/1ps
module sim_lpc_mailbox;
  logic lclk = 1'b0, lreset_n = 1'b0, lframe_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic lad_oe, host_irq;
  logic loc_we = 1'b0, loc_re = 1'b0;
  logic [5:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0, loc_rdata;

  lpc_mailbox u0 (.*);

  always #2.5 lclk = ~lclk;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_base [3];
  logic [2:0]  m_en, m_ien, m_ibf, m_obf, m_cd;
  logic [7:0]  m_in [3], m_out [3], m_ext [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic model_reset();
    m_en = '0; m_ien = '0; m_ibf = '0; m_obf = '0; m_cd = '0;
    for (int i = 0; i < 3; i++) begin m_base[i] = '0; m_in[i] = '0; m_out[i] = '0; end
    for (int i = 0; i < 16; i++) m_ext[i] = '0;
  endtask

  function automatic logic [7:0] m_status(input int c);
    return {4'b0, m_cd[c], 1'b0, m_ibf[c], m_obf[c]};
  endfunction

  task automatic decode(input logic [15:0] a, output bit hit, output int ch, output bit cd,
                        output bit ext, output int ei);
    logic [15:0] o;
    hit = 0; ch = 0; cd = 0; ext = 0; ei = 0;
    for (int i = 0; i < 3; i++)
      if (!hit && m_en[i] && (a == m_base[i] || a == 16'(m_base[i] + 16'd1))) begin
        hit = 1; ch = i; cd = (a != m_base[i]);
      end
    o = a - m_base[2];
    if (!hit && m_en[2] && o >= 16'h10 && o < 16'h20) begin hit = 1; ext = 1; ei = int'(o[3:0]); end
  endtask

  function automatic logic [7:0] m_local(input logic [5:0] a);
    int c;
    c = int'(a[4:3]);
    if (a[5]) return a[4] ? 8'h00 : m_ext[a[3:0]];
    if (c == 3) return 8'h00;
    case (a[2:0])
      3'd0: return m_in[c];
      3'd1: return m_out[c];
      3'd2: return m_status(c);
      3'd3: return m_base[c][7:0];
      3'd4: return m_base[c][15:8];
      3'd5: return {6'b0, m_ien[c], m_en[c]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic nib(input logic f, input logic [3:0] n);
    @(negedge lclk); lframe_n = f; lad_in = n;
  endtask

  task automatic host_cycle(input logic [3:0] ct, input logic [15:0] a, input logic [7:0] d,
                            output bit claimed, output logic [7:0] rd, output bit ok);
    nib(1'b0, 4'h0); nib(1'b1, ct);
    for (int i = 3; i >= 0; i--) nib(1'b1, a[4*i +: 4]);
    if (ct == 4'h2) begin nib(1'b1, d[3:0]); nib(1'b1, d[7:4]); end
    nib(1'b1, 4'hF); nib(1'b1, 4'hF);
    @(negedge lclk); claimed = lad_oe && lad_out == 4'h0; ok = 1; rd = 8'h00;
    if (claimed && ct == 4'h2) begin
      @(negedge lclk); ok &= lad_oe && lad_out == 4'hF;
      @(negedge lclk); ok &= !lad_oe;
    end else if (claimed) begin
      @(negedge lclk); rd[3:0] = lad_out; ok &= lad_oe;
      @(negedge lclk); rd[7:4] = lad_out; ok &= lad_oe;
      @(negedge lclk); ok &= lad_oe && lad_out == 4'hF;
      @(negedge lclk); ok &= !lad_oe;
    end else
      repeat (3) begin @(negedge lclk); ok &= !lad_oe; end
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [7:0] d);
    bit hit, cd, ext, cl, ok; int ch, ei; logic [7:0] rd;
    decode(a, hit, ch, cd, ext, ei);
    host_cycle(4'h2, a, d, cl, rd, ok);
    chk(cl == hit, "R2 write claim", 32'(cl), 32'(hit));
    chk(ok, "R4 write timing", 32'(ok), 1);
    if (hit) begin
      if (ext) m_ext[ei] = d;
      else begin m_in[ch] = d; m_ibf[ch] = 1; m_cd[ch] = cd; end
    end
  endtask

  task automatic hread(input logic [15:0] a);
    bit hit, cd, ext, cl, ok; int ch, ei; logic [7:0] rd, ex;
    decode(a, hit, ch, cd, ext, ei);
    ex = ext ? m_ext[ei] : cd ? m_status(ch) : m_out[ch];
    host_cycle(4'h0, a, 8'h00, cl, rd, ok);
    chk(cl == hit, "R2 read claim", 32'(cl), 32'(hit));
    chk(ok, "R5 read timing", 32'(ok), 1);
    if (hit) begin
      chk(rd == ex, ext ? "R8 window read" : "R7 host read data", 32'(rd), 32'(ex));
      if (!ext && !cd) m_obf[ch] = 0;
    end
  endtask

  task automatic lwrite(input logic [5:0] a, input logic [7:0] d);
    int c;
    @(negedge lclk); loc_we = 1; loc_addr = a; loc_wdata = d;
    @(negedge lclk); loc_we = 0;
    c = int'(a[4:3]);
    if (a[5]) begin if (!a[4]) m_ext[a[3:0]] = d; end
    else if (c != 3)
      case (a[2:0])
        3'd1: begin m_out[c] = d; m_obf[c] = 1; end
        3'd3: m_base[c][7:0] = d;
        3'd4: m_base[c][15:8] = d;
        3'd5: begin m_en[c] = d[0]; m_ien[c] = d[1]; end
        default: ;
      endcase
  endtask

  task automatic lread(input logic [5:0] a, input string req);
    logic [7:0] ex;
    ex = m_local(a);
    @(negedge lclk); loc_re = 1; loc_addr = a;
    #1 chk(loc_rdata == ex, req, 32'(loc_rdata), 32'(ex));
    @(negedge lclk); loc_re = 0;
    if (!a[5] && a[4:3] != 2'd3 && a[2:0] == 3'd0) m_ibf[a[4:3]] = 0;
  endtask

  task automatic irq_chk(input string req);
    bit ex;
    ex = |(m_obf & m_ien);
    @(negedge lclk); chk(host_irq == ex, req, 32'(host_irq), 32'(ex));
  endtask

  task automatic set_base(input int c, input logic [15:0] b, input logic [1:0] ctl);
    lwrite(6'(8*c + 3), b[7:0]); lwrite(6'(8*c + 4), b[15:8]); lwrite(6'(8*c + 5), {6'b0, ctl});
  endtask

  function automatic logic [15:0] pick_addr(input int r);
    case (r % 8)
      0: return m_base[0];
      1: return m_base[0] + 16'd1;
      2: return m_base[1];
      3: return m_base[1] + 16'd1;
      4: return m_base[2];
      5: return m_base[2] + 16'd1;
      6: return m_base[2] + 16'h10 + 16'($urandom_range(0, 15));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (400000) @(posedge lclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit cl, ok; logic [7:0] rd;
    void'($urandom(32'd2024));
    model_reset();
    repeat (4) @(negedge lclk);
    lreset_n = 1;
    @(negedge lclk);
    chk(!lad_oe && !host_irq, "R11 reset outputs", {lad_oe, host_irq}, 0);
    lread(6'h02, "R11 reset status"); lread(6'h0D, "R12 reset control");

    set_base(0, 16'h0060, 2'b01);
    set_base(1, 16'h0064, 2'b11);
    set_base(2, 16'hFFF0, 2'b01);
    lread(6'h0B, "R12 base low readback"); lread(6'h14, "R12 base high readback");
    lread(6'h30, "R12 unmapped reads zero");

    hwrite(16'h0060, 8'h5A);
    lread(6'h02, "R6 data write status");
    lread(6'h00, "R6 input byte");
    lread(6'h02, "R6 input-full cleared");
    hwrite(16'h0061, 8'hC3);
    lread(6'h02, "R6 command flag");

    lwrite(6'h09, 8'h77); irq_chk("R9 irq raised");
    hread(16'h0065); irq_chk("R9 status read keeps irq");
    hread(16'h0064); irq_chk("R9 irq cleared by host read");
    lread(6'h0A, "R7 output-full cleared");

    hwrite(16'h0005, 8'h99); lread(6'h25, "R8 host to local window wrap");
    lwrite(6'h2F, 8'h11); hread(16'h000F);

    host_cycle(4'h4, 16'h0060, 8'hEE, cl, rd, ok);
    chk(!cl && ok, "R1 other cycle type not driven", {cl, ok}, 1);
    lread(6'h02, "R1 other cycle type no effect");

    hwrite(16'h0062, 8'h01);
    lwrite(6'h05, 8'h00); hwrite(16'h0060, 8'h02); lread(6'h02, "R2 disabled channel untouched");
    lwrite(6'h05, 8'h01);

    set_base(2, 16'h0060, 2'b01);
    hwrite(16'h0060, 8'h3C);
    lread(6'h12, "R10 ch3 not hit on overlap"); lread(6'h02, "R10 ch1 wins overlap");
    lread(6'h00, "R10 ch1 data");
    set_base(1, 16'hFFE0, 2'b11);
    set_base(2, 16'hFFD0, 2'b01);
    hwrite(16'hFFE0, 8'h4D); lread(6'h0A, "R10 pair beats window");
    lread(6'h20, "R10 window untouched"); lread(6'h08, "R10 ch2 data");
    set_base(1, 16'h0064, 2'b11);
    set_base(2, 16'hFFF0, 2'b01);

    nib(1'b0, 4'h0); nib(1'b1, 4'h2); nib(1'b1, 4'h0); nib(1'b1, 4'h0);
    nib(1'b0, 4'hF); nib(1'b1, 4'h6); nib(1'b1, 4'h0);
    repeat (4) begin @(negedge lclk); chk(!lad_oe, "R3 aborted cycle not driven", lad_oe, 0); end
    lread(6'h02, "R3 aborted cycle no effect");
    hwrite(16'h0060, 8'hA5); lread(6'h00, "R3 recovery after abort");

    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom_range(0, 5));
      case (r)
        0, 1: hwrite(pick_addr(int'($urandom)), 8'($urandom));
        2: hread(pick_addr(int'($urandom)));
        3: lwrite($urandom_range(0, 1) ? 6'(8*$urandom_range(0, 2) + 1) : 6'(32 + $urandom_range(0, 15)), 8'($urandom));
        4: lread(6'(8*$urandom_range(0, 2) + $urandom_range(0, 2)), "R6 R7 random local read");
        default: begin lread(6'(32 + $urandom_range(0, 15)), "R8 random window read"); irq_chk("R9 random irq"); end
      endcase
    end

    lwrite(6'h09, 8'h42);
    @(negedge lclk); lreset_n = 0;
    @(negedge lclk); model_reset();
    chk(!host_irq && !lad_oe, "R11 reset clears irq", {host_irq, lad_oe}, 0);
    lreset_n = 1;
    lread(6'h0A, "R11 flags cleared"); lread(6'h0B, "R11 base cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule